// File: doc/BRIEF.md
# Host-Port Interrupt Register Block

This peripheral sits on a 32-bit request/acknowledge register bus. It holds six 32-bit software registers and drives one level-sensitive interrupt line toward a system interrupt controller. The line does not come from per-source enables or masks. It is a single latch, and register writes set or clear it as a side effect, depending on which register is written and, for some registers, on particular data bits.

Each register keeps the whole word last written to it. Software can read any of them back. A read of the control register always shows a ready flag at bit 17, whatever was stored there. The decoded window is 0x200 bytes inside a 4 KiB region. An address that matches none of the six word offsets counts as unmapped. This includes misaligned addresses and addresses aliased above the window. Every request, read or write, is acknowledged one cycle later. Read data is valid during that acknowledge cycle.

Top module: `hpirq_regblk`

## Requirements
- R1: After reset, and after any later reset, `irq_o` and `rsp_ack` are 0 and all six registers hold zero. A control read then returns 0x0002_0000 and every other register reads 0.
- R2: Each register stores the full 32-bit word written to it and returns it on a read. The byte offsets are: descriptor A 0x028, descriptor B 0x02C, control 0x04C, interrupt status 0x050, software set 0x1F0, software clear 0x1F4.
- R3: A read of the control register returns the stored word with bit 17 forced to 1.
- R4: A write to descriptor B with data bit 29 set asserts `irq_o`. The same write with bit 29 clear leaves `irq_o` unchanged.
- R5: A write to control with data bit 16 set deasserts `irq_o`. With bit 16 clear, `irq_o` is left unchanged.
- R6: A write to interrupt status with data bit 16 or data bit 29 set deasserts `irq_o`. With neither bit set, `irq_o` is left unchanged.
- R7: Any write to the software set register asserts `irq_o`, and any write to the software clear register deasserts it, whatever the data.
- R8: A write to descriptor A never changes `irq_o`.
- R9: An address that matches none of the six offsets is unmapped. This covers misaligned addresses, other offsets in the window, and aliases at 0x200 and above. A read of an unmapped address returns 0. A write to one changes no register and leaves `irq_o` unchanged.
- R10: `rsp_ack` is high exactly in the cycle after each request, and read data is valid in that cycle. `irq_o` changes at the clock edge that captures the write, then holds until another setting or clearing write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KiB region |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with acknowledge |
| irq_o | output | 1 | Level interrupt to the controller |

## Verification
The hardest case to reach from the ports is a write that must do nothing while the line is already in the state that write could have changed. Examples are an unmapped write carrying a clearing bit pattern while `irq_o` is high, or a descriptor B write with bit 29 clear after a clear. To build these cases, the stimulus table first drives the line to the opposite level with a software-set or clearing write. Only then does it apply the write that should have no effect. It then reads the aliased or unmapped address back to show that no register was touched.

// File: rtl/hpirq_pkg.sv
package hpirq_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 6;

    // register slots
    localparam int IX_DESC_A = 0;
    localparam int IX_DESC_B = 1;
    localparam int IX_CTRL   = 2;
    localparam int IX_ISTAT  = 3;
    localparam int IX_SWSET  = 4;
    localparam int IX_SWCLR  = 5;

    // byte offsets of the slots, indexed by slot number
    localparam int unsigned SLOT_OFFSET [NUM_REGS] = '{
        32'h028, 32'h02C, 32'h04C, 32'h050, 32'h1F0, 32'h1F4
    };

    // data bits with side effects
    localparam int DESCB_SET_BIT  = 29;
    localparam int CTRL_CLR_BIT   = 16;
    localparam int ISTAT_CLR_LO   = 16;
    localparam int ISTAT_CLR_HI   = 29;
    localparam int CTRL_READY_BIT = 17;

endpackage

// File: rtl/hpirq_decode.sv
module hpirq_decode
    import hpirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [NUM_REGS-1:0] sel_o,
    output logic                hit_o,
    output logic                irq_set_o,
    output logic                irq_clr_o
);

    logic [NUM_REGS-1:0] match;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_match
            assign match[gi] = (req_addr == ADDR_W'(SLOT_OFFSET[gi]));
        end
    endgenerate

    logic wr;

    always_comb begin
        wr        = req_valid && req_write;
        sel_o     = match;
        hit_o     = |match;
        irq_set_o = wr && (match[IX_SWSET] ||
                           (match[IX_DESC_B] && req_wdata[DESCB_SET_BIT]));
        irq_clr_o = wr && (match[IX_SWCLR] ||
                           (match[IX_CTRL] && req_wdata[CTRL_CLR_BIT]) ||
                           (match[IX_ISTAT] && (req_wdata[ISTAT_CLR_LO] ||
                                                req_wdata[ISTAT_CLR_HI])));
    end

endmodule

// File: rtl/hpirq_regs.sv
module hpirq_regs
    import hpirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [NUM_REGS-1:0] sel_i,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                ack_o,
    output logic [DATA_W-1:0]   rdata_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            ack;
        logic [DATA_W-1:0]               rdata;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic [NUM_REGS-1:0] wr_en;
    logic [NUM_REGS-1:0] rd_en;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_en
            assign wr_en[gi] = req_valid &&  req_write && sel_i[gi];
            assign rd_en[gi] = req_valid && !req_write && sel_i[gi];
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.ack   = req_valid;
        st_d.rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en[i]) st_d.regs[i] = req_wdata;
            if (rd_en[i]) st_d.rdata   = st_d.rdata | st_q.regs[i];
        end
        if (rd_en[IX_CTRL]) st_d.rdata[CTRL_READY_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o   = st_q.ack;
    assign rdata_o = st_q.rdata;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_i)); // R2
    AST_STORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[IX_DESC_A] |=> st_q.regs[IX_DESC_A] == $past(req_wdata)); // R2

endmodule

// File: rtl/hpirq_latch.sv
module hpirq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    typedef struct packed {
        logic irq;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.irq = 1'b1;
        else if (clr_i) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o); // R7
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o); // R5
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_o)); // R10

endmodule

// File: rtl/hpirq_regblk.sv
module hpirq_regblk
    import hpirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ack,
    output logic [31:0]       rsp_rdata,
    output logic              irq_o
);

    logic [NUM_REGS-1:0] sel;
    logic                hit;
    logic                irq_set;
    logic                irq_clr;

    hpirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_o     (sel),
        .hit_o     (hit),
        .irq_set_o (irq_set),
        .irq_clr_o (irq_clr)
    );

    hpirq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .sel_i     (sel),
        .req_wdata (req_wdata),
        .ack_o     (rsp_ack),
        .rdata_o   (rsp_rdata)
    );

    hpirq_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .clr_i (irq_clr),
        .irq_o (irq_o)
    );

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack); // R10
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ack); // R10
    AST_CTRL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel[IX_CTRL]) |=> rsp_rdata[CTRL_READY_BIT]); // R3
    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !hit) |=> rsp_rdata == '0); // R9
    AST_UNMAPPED_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !hit) |=> $stable(irq_o)); // R9
    AST_DESCA_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel[IX_DESC_A]) |=> $stable(irq_o)); // R8
    AST_DESCB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel[IX_DESC_B] && req_wdata[DESCB_SET_BIT])
        |=> irq_o); // R4
    AST_ISTAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel[IX_ISTAT] &&
         (req_wdata[ISTAT_CLR_LO] || req_wdata[ISTAT_CLR_HI])) |=> !irq_o); // R6

endmodule

// File: tb/hpirq_regblk_bench.sv
`timescale 1ns/1ps
module hpirq_regblk_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ack;
    logic [31:0] rsp_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hpirq_regblk u_hpirq_regblk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata),
        .irq_o     (irq_o)
    );

    localparam int NV = 27;
    localparam bit          V_WR   [NV] = '{1,0,1,0,1,1,0,1,0,1,1,1,1,0,1,1,1,1,1,0,1,0,0,1,1,0,0};
    localparam logic [11:0] V_ADDR [NV] = '{
        12'h028, 12'h028, 12'h02C, 12'h02C, 12'h028, 12'h04C, 12'h04C, 12'h04C, 12'h04C,
        12'h1F0, 12'h050, 12'h1F0, 12'h050, 12'h050, 12'h050, 12'h02C, 12'h1F0, 12'h1F8,
        12'h04E, 12'h1F8, 12'h1F4, 12'h1F4, 12'h1F0, 12'h1F0, 12'h250, 12'h228, 12'h02C};
    localparam logic [31:0] V_DATA [NV] = '{
        32'hFFFF_FFFF, 32'h0, 32'h2000_0000, 32'h0, 32'h0, 32'h0000_0001, 32'h0, 32'h0001_0000, 32'h0,
        32'h0, 32'h2000_0000, 32'h1234_5678, 32'h0000_0004, 32'h0, 32'h0001_0000, 32'hDFFF_FFFF, 32'hA5A5_A5A5, 32'hFFFF_FFFF,
        32'h0001_0000, 32'h0, 32'h0000_FFFF, 32'h0, 32'h0, 32'hA5A5_A5A5, 32'h0001_0000, 32'h0, 32'h0};
    localparam logic [31:0] V_EXP  [NV] = '{
        32'h0, 32'hFFFF_FFFF, 32'h0, 32'h2000_0000, 32'h0, 32'h0, 32'h0002_0001, 32'h0, 32'h0003_0000,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0004, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0000_FFFF, 32'hA5A5_A5A5, 32'h0, 32'h0, 32'h0, 32'hDFFF_FFFF};
    localparam bit          V_IRQ  [NV] = '{0,0,1,1,1,1,1,0,0,1,0,1,1,1,0,0,1,1,1,1,0,0,0,1,1,1,1};
    // requirement per row:
    //  0 R8  1 R2  2 R4  3 R2  4 R8  5 R5  6 R3  7 R5  8 R3
    //  9 R7 10 R6 11 R7 12 R6 13 R2 14 R6 15 R4 16 R7 17 R9
    // 18 R9 19 R9 20 R7 21 R2 22 R2 23 R7 24 R9 25 R9 26 R2
    localparam int          V_REQ  [NV] = '{8,2,4,2,8,5,3,5,3,7,6,7,6,2,6,4,7,9,9,9,7,2,2,7,9,9,2};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one request; returns at the falling edge after the capturing edge
    task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check_reset_regs(input string tag);
        for (int i = 0; i < 6; i++) begin
            logic [11:0] a;
            a = (i == 0) ? 12'h028 : (i == 1) ? 12'h02C : (i == 2) ? 12'h04C :
                (i == 3) ? 12'h050 : (i == 4) ? 12'h1F0 : 12'h1F4;
            xfer(1'b0, a, 32'h0);
            chk(tag, rsp_rdata, (i == 2) ? 32'h0002_0000 : 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        chk("R1 ack in reset", {31'b0, rsp_ack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        check_reset_regs("R1 reset register value");

        // R10: idle cycle gives no acknowledge
        @(negedge clk);
        chk("R10 idle ack", {31'b0, rsp_ack}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            xfer(V_WR[v], V_ADDR[v], V_DATA[v]);
            chk($sformatf("R10 ack row %0d", v), {31'b0, rsp_ack}, 32'h1);
            if (!V_WR[v])
                chk($sformatf("R%0d rdata row %0d", V_REQ[v], v), rsp_rdata, V_EXP[v]);
            chk($sformatf("R%0d irq row %0d", V_REQ[v], v), {31'b0, irq_o}, {31'b0, V_IRQ[v]});
        end

        // R10: irq holds through idle cycles, ack drops after its pulse
        repeat (5) @(negedge clk);
        chk("R10 irq held", {31'b0, irq_o}, 32'h1);
        chk("R10 ack single pulse", {31'b0, rsp_ack}, 32'h0);

        // R4: descriptor B write without bit 29 while high leaves it high
        xfer(1'b1, 12'h02C, 32'h0000_0001);
        chk("R4 no-set write keeps irq", {31'b0, irq_o}, 32'h1);

        // R1: reset in mid-run clears irq and the registers
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-run reset irq", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        check_reset_regs("R1 mid-run reset register");

        done = 1'b1;
        report();
        $finish;
    end

endmodule